// File: doc/BRIEF.md
# Multiported Register File With Write Forwarding

This block is a storage array of general-purpose data words with several read ports and several write ports, all working in the same cycle. Every port decodes its own address into a one-hot row select. Each write port has its own enable; an enabled write is stored into its entry on the rising clock edge. Read data is produced combinationally from the read address. When a read addresses an entry that is being written in the same cycle, the read returns the incoming write data instead of the stored word.

The issue logic that feeds the file is expected to enable at most one write per entry in any cycle. The file does not arbitrate between write ports. It does define a fixed outcome when that rule is broken: the highest-numbered enabled port wins, both in storage and on the forwarding path. A collision flag reports the event in the same cycle.

The number of entries, the word width and both port counts are parameters. The defaults are 32 entries of 64 bits, 4 read ports and 2 write ports.

Top module: `multiport_regfile`

## Requirements
- R1: After the asynchronous reset `rst_ni` is released, every entry reads as zero on every read port until it is written.
- R2: A write whose enable is high is stored on the rising clock edge. From the next cycle on, the stored word is visible on any read port that addresses the entry.
- R3: A write port whose enable is low changes no entry, whatever its address and data are.
- R4: Enabled write ports that target different entries in the same cycle all commit at that edge.
- R5: A read port that addresses an entry being written by an enabled port in the same cycle returns that port's write data in that same cycle.
- R6: When two or more enabled write ports target the same entry, the entry stores the data of the highest-numbered of those ports.
- R7: During such a collision, a read of the contended entry returns, in the same cycle, the data of the highest-numbered enabled port targeting it.
- R8: `wr_clash_o` is high in a cycle exactly when at least two enabled write ports carry the same address. A matching address on a disabled port does not raise it.
- R9: Read ports are independent. Each one returns its own addressed word in the same cycle, under arbitrary mixed traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; writes commit on the rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low; clears all entries |
| we_i | input | NUM_WR | Write enable, one bit per write port |
| waddr_i | input | NUM_WR x ADDR_W | Write address per write port |
| wdata_i | input | NUM_WR x DATA_W | Write data per write port |
| raddr_i | input | NUM_RD x ADDR_W | Read address per read port |
| rdata_o | output | NUM_RD x DATA_W | Read data per read port, combinational and forwarded |
| wr_clash_o | output | 1 | High when two enabled write ports share an address |

## Verification
Read data and the collision flag are combinational, so the bench compares them in the same cycle the inputs are applied, one time unit after driving them at the falling edge. Stored effects of a write become due one rising edge later. The reference model updates its array only at that edge, in ascending port order, so the last port applied wins. The reads in the following cycle then show whether the commit, the ignored enable or the collision priority came out right.

// File: rtl/rf_pkg.sv
package rf_pkg;
  parameter int unsigned RF_ENTRIES = 32;
  parameter int unsigned RF_DATA_W  = 64;
  parameter int unsigned RF_NUM_RD  = 4;
  parameter int unsigned RF_NUM_WR  = 2;
endpackage

// File: rtl/rf_addr_dec.sv
module rf_addr_dec #(
  parameter int unsigned N  = 32,
  parameter int unsigned AW = 5
) (
  input  logic          en_i,
  input  logic [AW-1:0] addr_i,
  output logic [N-1:0]  sel_o
);
  for (genvar i = 0; i < N; i++) begin : g_row
    assign sel_o[i] = en_i && (addr_i == AW'(i));
  end
endmodule

// File: rtl/rf_entry.sv
module rf_entry #(
  parameter int unsigned DW = 64,
  parameter int unsigned NW = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NW-1:0]        hit_i,
  input  logic [NW-1:0][DW-1:0] wdata_i,
  output logic [DW-1:0]        q_o
);
  logic [DW-1:0] nxt;

  // ascending scan: highest-numbered hitting port wins
  always_comb begin
    nxt = q_o;
    for (int p = 0; p < int'(NW); p++)
      if (hit_i[p]) nxt = wdata_i[p];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (|hit_i) q_o <= nxt;
  end
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port #(
  parameter int unsigned N  = 32,
  parameter int unsigned DW = 64,
  parameter int unsigned NW = 2,
  parameter int unsigned AW = 5
) (
  input  logic [AW-1:0]         raddr_i,
  input  logic [N-1:0][DW-1:0]  mem_i,
  input  logic [NW-1:0]         we_i,
  input  logic [NW-1:0][AW-1:0] waddr_i,
  input  logic [NW-1:0][DW-1:0] wdata_i,
  output logic [DW-1:0]         rdata_o
);
  logic [N-1:0]  rsel;
  logic [DW-1:0] arr_q;

  rf_addr_dec #(.N(N), .AW(AW)) u_dec (
    .en_i  (1'b1),
    .addr_i(raddr_i),
    .sel_o (rsel)
  );

  always_comb begin
    arr_q = '0;
    for (int e = 0; e < int'(N); e++)
      arr_q |= {DW{rsel[e]}} & mem_i[e];
  end

  always_comb begin
    rdata_o = arr_q;
    for (int p = 0; p < int'(NW); p++)
      if (we_i[p] && (waddr_i[p] == raddr_i)) rdata_o = wdata_i[p];
  end
endmodule

// File: rtl/multiport_regfile.sv
module multiport_regfile #(
  parameter  int unsigned NUM_ENTRIES = rf_pkg::RF_ENTRIES,
  parameter  int unsigned DATA_W      = rf_pkg::RF_DATA_W,
  parameter  int unsigned NUM_RD      = rf_pkg::RF_NUM_RD,
  parameter  int unsigned NUM_WR      = rf_pkg::RF_NUM_WR,
  localparam int unsigned ADDR_W      = $clog2(NUM_ENTRIES)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [NUM_WR-1:0]                we_i,
  input  logic [NUM_WR-1:0][ADDR_W-1:0]    waddr_i,
  input  logic [NUM_WR-1:0][DATA_W-1:0]    wdata_i,
  input  logic [NUM_RD-1:0][ADDR_W-1:0]    raddr_i,
  output logic [NUM_RD-1:0][DATA_W-1:0]    rdata_o,
  output logic                             wr_clash_o
);
  logic [NUM_WR-1:0][NUM_ENTRIES-1:0] wsel;
  logic [NUM_ENTRIES-1:0][NUM_WR-1:0] ehit;
  logic [NUM_ENTRIES-1:0][DATA_W-1:0] mem;

  for (genvar w = 0; w < NUM_WR; w++) begin : g_wdec
    rf_addr_dec #(.N(NUM_ENTRIES), .AW(ADDR_W)) u_dec (
      .en_i  (we_i[w]),
      .addr_i(waddr_i[w]),
      .sel_o (wsel[w])
    );
  end

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_ent
    for (genvar w = 0; w < NUM_WR; w++) begin : g_t
      assign ehit[e][w] = wsel[w][e];
    end
    rf_entry #(.DW(DATA_W), .NW(NUM_WR)) u_ent (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .hit_i  (ehit[e]),
      .wdata_i(wdata_i),
      .q_o    (mem[e])
    );
  end

  for (genvar r = 0; r < NUM_RD; r++) begin : g_rd
    rf_read_port #(.N(NUM_ENTRIES), .DW(DATA_W), .NW(NUM_WR), .AW(ADDR_W)) u_rp (
      .raddr_i(raddr_i[r]),
      .mem_i  (mem),
      .we_i   (we_i),
      .waddr_i(waddr_i),
      .wdata_i(wdata_i),
      .rdata_o(rdata_o[r])
    );
  end

  // a row hit by two or more decoders is a collision
  always_comb begin
    wr_clash_o = 1'b0;
    for (int e = 0; e < int'(NUM_ENTRIES); e++)
      if ($countones(ehit[e]) > 1) wr_clash_o = 1'b1;
  end
endmodule

// File: rtl/multiport_regfile_chk.sv
module multiport_regfile_chk #(
  parameter  int unsigned NUM_ENTRIES = 32,
  parameter  int unsigned DATA_W      = 64,
  parameter  int unsigned NUM_RD      = 4,
  parameter  int unsigned NUM_WR      = 2,
  localparam int unsigned ADDR_W      = $clog2(NUM_ENTRIES)
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic [NUM_WR-1:0]             we_i,
  input logic [NUM_WR-1:0][ADDR_W-1:0] waddr_i,
  input logic [NUM_WR-1:0][DATA_W-1:0] wdata_i,
  input logic [NUM_RD-1:0][ADDR_W-1:0] raddr_i,
  input logic [NUM_RD-1:0][DATA_W-1:0] rdata_o,
  input logic                          wr_clash_o
);
  logic                          any_wr, prev_ok;
  logic [NUM_WR-1:0]             p_we;
  logic [NUM_WR-1:0][ADDR_W-1:0] p_wa;
  logic [NUM_WR-1:0][DATA_W-1:0] p_wd;
  logic [NUM_RD-1:0]             cur_hit, prv_hit;
  logic [NUM_RD-1:0][DATA_W-1:0] cur_d, prv_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      any_wr <= 1'b0; prev_ok <= 1'b0;
      p_we <= '0; p_wa <= '0; p_wd <= '0;
    end else begin
      any_wr  <= any_wr | (|we_i);
      prev_ok <= 1'b1;
      p_we <= we_i; p_wa <= waddr_i; p_wd <= wdata_i;
    end
  end

  always_comb begin
    for (int r = 0; r < int'(NUM_RD); r++) begin
      cur_hit[r] = 1'b0; cur_d[r] = '0;
      prv_hit[r] = 1'b0; prv_d[r] = '0;
      for (int w = 0; w < int'(NUM_WR); w++) begin
        if (we_i[w] && waddr_i[w] == raddr_i[r]) begin cur_hit[r] = 1'b1; cur_d[r] = wdata_i[w]; end
        if (p_we[w] && p_wa[w] == raddr_i[r])    begin prv_hit[r] = 1'b1; prv_d[r] = p_wd[w]; end
      end
    end
  end

  for (genvar r = 0; r < NUM_RD; r++) begin : g_r
    assert_bypass_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cur_hit[r] |-> rdata_o[r] == cur_d[r]);
    assert_commit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (prev_ok && prv_hit[r] && !cur_hit[r]) |-> rdata_o[r] == prv_d[r]);
    assert_reset_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!any_wr && !(|we_i)) |-> rdata_o[r] == '0);
  end

  assert_clash_needs_two_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_clash_o |-> $countones(we_i) >= 2);
  assert_clash_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(we_i) < 2) |-> !wr_clash_o);
endmodule

bind multiport_regfile multiport_regfile_chk #(
  .NUM_ENTRIES(NUM_ENTRIES), .DATA_W(DATA_W), .NUM_RD(NUM_RD), .NUM_WR(NUM_WR)
) u_chk (.*);

// File: tb/multiport_regfile_test.sv
module multiport_regfile_test;
  localparam int NE = 32, DW = 64, NR = 4, NW = 2, AW = 5;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic [NW-1:0]        we = '0;
  logic [NW-1:0][AW-1:0] wa = '0;
  logic [NW-1:0][DW-1:0] wd = '0;
  logic [NR-1:0][AW-1:0] ra = '0;
  logic [NR-1:0][DW-1:0] rd;
  logic                 clash;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [DW-1:0] model [NE];

  always #4 clk = ~clk;

  multiport_regfile uut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .waddr_i(wa), .wdata_i(wd),
    .raddr_i(ra), .rdata_o(rd), .wr_clash_o(clash)
  );

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // inputs already driven after a falling edge; compare, then commit at rising edge
  task automatic cycle(input string tag);
    logic [DW-1:0] e;
    bit c;
    #1;
    for (int r = 0; r < NR; r++) begin
      e = model[ra[r]];
      for (int w = 0; w < NW; w++) if (we[w] && wa[w] == ra[r]) e = wd[w];
      check(tag, rd[r], e);
    end
    c = 0;
    for (int i = 0; i < NW; i++)
      for (int j = i + 1; j < NW; j++)
        if (we[i] && we[j] && wa[i] == wa[j]) c = 1;
    check({tag, "/R8 clash"}, {63'd0, clash}, {63'd0, c});
    @(posedge clk);
    for (int w = 0; w < NW; w++) if (we[w]) model[wa[w]] = wd[w];
    @(negedge clk);
  endtask

  task automatic idle_reads(input int a0, input int a1, input int a2, input int a3);
    we = '0;
    ra[0] = AW'(a0); ra[1] = AW'(a1); ra[2] = AW'(a2); ra[3] = AW'(a3);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NE; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: all entries zero after reset
    for (int b = 0; b < NE; b += 4) begin
      idle_reads(b, b + 1, b + 2, b + 3);
      cycle("R1 reset zero");
    end

    // R3: disabled ports with data change nothing
    we = '0; wa[0] = 5'd3; wa[1] = 5'd4;
    wd[0] = 64'hDEAD_0000_0000_0003; wd[1] = 64'hDEAD_0000_0000_0004;
    ra[0] = 5'd3; ra[1] = 5'd4; ra[2] = 5'd0; ra[3] = 5'd31;
    cycle("R3 disabled write");
    idle_reads(3, 4, 3, 4);
    cycle("R3 entries unchanged");

    // R2: single write, visible next cycle on all ports
    we = 2'b01; wa[0] = 5'd5; wd[0] = 64'h0123_4567_89AB_CDEF;
    ra = '0;
    cycle("R2 write");
    idle_reads(5, 5, 5, 5);
    cycle("R2 readback");

    // R4: two ports, distinct entries
    we = 2'b11; wa[0] = 5'd7; wa[1] = 5'd9;
    wd[0] = 64'hAAAA_0000_0000_0007; wd[1] = 64'h5555_0000_0000_0009;
    idle_reads(1, 2, 6, 8); we = 2'b11;
    cycle("R4 dual write");
    idle_reads(7, 9, 5, 0);
    cycle("R4 readback");

    // R5: same-cycle forwarding on both port numbers
    we = 2'b11; wa[0] = 5'd12; wa[1] = 5'd31;
    wd[0] = 64'hFEED_FACE_0000_000C; wd[1] = 64'hFFFF_FFFF_FFFF_FFFF;
    ra[0] = 5'd12; ra[1] = 5'd31; ra[2] = 5'd7; ra[3] = 5'd12;
    cycle("R5 forward");
    idle_reads(12, 31, 0, 9);
    cycle("R5 stored");

    // R6/R7/R8: collision, port 1 wins
    we = 2'b11; wa[0] = 5'd20; wa[1] = 5'd20;
    wd[0] = 64'h0000_0000_0000_1111; wd[1] = 64'h0000_0000_0000_2222;
    ra[0] = 5'd20; ra[1] = 5'd20; ra[2] = 5'd5; ra[3] = 5'd0;
    cycle("R7 collision forward");
    idle_reads(20, 20, 20, 20);
    cycle("R6 collision stored");

    // R8: same address, only one port enabled: no clash
    we = 2'b01; wa[0] = 5'd21; wa[1] = 5'd21;
    wd[0] = 64'h0000_0000_0000_3333; wd[1] = 64'h0000_0000_0000_4444;
    ra[0] = 5'd21; ra[1] = 5'd20; ra[2] = 5'd21; ra[3] = 5'd1;
    cycle("R8 single enable");
    idle_reads(21, 21, 21, 21);
    cycle("R3 disabled port ignored");

    // R9: mixed traffic, narrow address range to provoke collisions
    for (int n = 0; n < 400; n++) begin
      we = NW'($urandom);
      for (int w = 0; w < NW; w++) begin
        wa[w] = AW'($urandom_range(0, 7));
        wd[w] = {$urandom, $urandom};
      end
      for (int r = 0; r < NR; r++) ra[r] = AW'($urandom_range(0, 9));
      cycle("R9 mixed");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule